// File: doc/BRIEF.md
# Strobe-Paced Light Pattern Sequencer

This block drives an 8-bit lamp output through a fixed loop of six symmetric light patterns. The light first widens from the centre, then splits and shrinks towards the two edges. The sequence is held in a Moore state machine of three state bits. The 8-bit output is decoded from the state, so the pattern itself is not stored in registers.

Every register runs on the one fast system clock. A free-running cycle counter raises a strobe that is one clock wide each time it reaches a terminal count. The sequencer moves one step only in a cycle where this strobe and the external enable are both high. The pacing is therefore a clock enable and not a divided clock. The terminal count is a parameter. The default of 49_999_999 gives a 500 ms step at 100 MHz, and a bench can set a small value.

States, in the order they are visited: `ST_NARROW` (00011000), `ST_MID` (00111100), `ST_WIDE` (01111110), `ST_SPLIT` (11100111), `ST_EDGE` (11000011), `ST_RIM` (10000001). The transitions are NARROW→MID, MID→WIDE, WIDE→SPLIT, SPLIT→EDGE, EDGE→RIM and RIM→NARROW, each taken on a step. Every state holds when there is no step. The two unused state codes go to `ST_NARROW` on the next step, and while in them the output reads zero.

Top module: `lamp_pattern_engine`

## Requirements
- R1: Output values are 0x18, 0x3C, 0x7E, 0xE7, 0xC3 and 0x81, in that order. After 0x81 the output returns to 0x18.
- R2: The output advances by exactly one pattern at the rising edge that ends a cycle in which both `step_en` and the internal strobe are 1. It does not change at any other edge.
- R3: While `step_en` is 0 the output holds its value for any number of cycles.
- R4: Driving `rst_n` low sets the output to 0x18 at once, without a clock edge, and clears the strobe counter.
- R5: The strobe is high for exactly one cycle out of every `TICK_LAST`+1 cycles. With `step_en` held at 1 from reset release, the first change happens at the (`TICK_LAST`+1)-th rising edge after release. Each later change follows `TICK_LAST`+1 edges after the one before.
- R6: The strobe counter keeps running while `step_en` is 0. When `step_en` returns to 1, the next step falls on the existing strobe phase and not on a restarted count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock; the only clock in the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | External enable; steps are allowed while it is high |
| lamps | output | 8 | Current light pattern |

## Verification
A step is due at the rising edge that ends a cycle in which the strobe and `step_en` are both high. The strobe is high in the cycle after the `TICK_LAST`-th edge of each count. So with a short terminal count of 4, a change is due every fifth edge, and no change is due while the enable is low. Reset is the exception: it acts at once, with no edge. The bench updates its own model at each rising edge from the enable it drove at the previous falling edge. It compares the output at the following falling edge, half a period after the register update. Targeted checks count edges from reset release and sample the output just before and just after the expected step edge.

// File: rtl/lpe_pkg.sv
package lpe_pkg;

    typedef enum logic [2:0] {
        ST_NARROW = 3'd0,
        ST_MID    = 3'd1,
        ST_WIDE   = 3'd2,
        ST_SPLIT  = 3'd3,
        ST_EDGE   = 3'd4,
        ST_RIM    = 3'd5
    } lpe_state_e;

    localparam int LAMP_W = 8;

endpackage

// File: rtl/lpe_tick_gen.sv
module lpe_tick_gen #(
    parameter int TICK_LAST = 49_999_999
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (TICK_LAST < 1) ? 1 : $clog2(TICK_LAST + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_LAST);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    generate
        if (TICK_LAST > 0) begin : g_width_chk
            assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/lpe_step_fsm.sv
module lpe_step_fsm
    import lpe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    output lpe_state_e state
);
    lpe_state_e state_q;
    lpe_state_e state_d;

    always_comb begin
        unique case (state_q)
            ST_NARROW: state_d = ST_MID;
            ST_MID:    state_d = ST_WIDE;
            ST_WIDE:   state_d = ST_SPLIT;
            ST_SPLIT:  state_d = ST_EDGE;
            ST_EDGE:   state_d = ST_RIM;
            ST_RIM:    state_d = ST_NARROW;
            default:   state_d = ST_NARROW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_NARROW;
        else if (step)
            state_q <= state_d;
    end

    assign state = state_q;

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state_q));

    assert_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (state_q != $past(state_q)));

    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step && state_q == ST_RIM) |=> (state_q == ST_NARROW));

    assert_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state_q <= ST_RIM);

endmodule

// File: rtl/lpe_pattern_dec.sv
module lpe_pattern_dec
    import lpe_pkg::*;
(
    input  lpe_state_e        state,
    output logic [LAMP_W-1:0] lamps
);
    always_comb begin
        unique case (state)
            ST_NARROW: lamps = 8'b0001_1000;
            ST_MID:    lamps = 8'b0011_1100;
            ST_WIDE:   lamps = 8'b0111_1110;
            ST_SPLIT:  lamps = 8'b1110_0111;
            ST_EDGE:   lamps = 8'b1100_0011;
            ST_RIM:    lamps = 8'b1000_0001;
            default:   lamps = '0;
        endcase
    end
endmodule

// File: rtl/lamp_pattern_engine.sv
module lamp_pattern_engine
    import lpe_pkg::*;
#(
    parameter int TICK_LAST = 49_999_999
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_en,
    output logic [7:0] lamps
);
    logic       tick;
    logic       step;
    lpe_state_e state;

    lpe_tick_gen #(.TICK_LAST(TICK_LAST)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    assign step = tick & step_en;

    lpe_step_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .state (state)
    );

    lpe_pattern_dec u_dec (
        .state (state),
        .lamps (lamps)
    );

    // Every legal pattern is mirror-symmetric and lights 2, 4 or 6 lamps (R1).
    assert_mirror_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lamps == {lamps[0], lamps[1], lamps[2], lamps[3],
                  lamps[4], lamps[5], lamps[6], lamps[7]});

    assert_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(lamps) == 2) || ($countones(lamps) == 4) || ($countones(lamps) == 6));

    assert_no_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && step_en) |=> $stable(lamps));

endmodule

// File: tb/sim_lamp_pattern_engine.sv
module sim_lamp_pattern_engine;
    localparam int CLK_PERIOD = 10;
    localparam int TL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_en = 1'b0;
    logic [7:0] lamps;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    int m_cnt = 0;
    int m_idx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lamp_pattern_engine #(.TICK_LAST(TL)) u0 (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .lamps(lamps)
    );

    function automatic logic [7:0] pat(int i);
        case (i)
            0: return 8'h18;
            1: return 8'h3C;
            2: return 8'h7E;
            3: return 8'hE7;
            4: return 8'hC3;
            default: return 8'h81;
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: lamps=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: one expected item per rising edge (R1, R2, R5, R6).
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0;
            m_idx = 0;
            exp_q.delete();
        end else begin
            if (m_cnt == TL) begin
                if (step_en) m_idx = (m_idx + 1) % 6;
                m_cnt = 0;
            end else begin
                m_cnt = m_cnt + 1;
            end
            exp_q.push_back(pat(m_idx));
        end
    end

    // Monitor: compares one item at each falling edge.
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0)
            check("R1/R2/R3/R6", lamps, exp_q.pop_front());
    end

    task automatic drive(bit en, int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            step_en = en;
        end
    endtask

    initial begin
        #(CLK_PERIOD*3 + 2);
        check("R4", lamps, 8'h18);
        @(negedge clk);
        rst_n = 1'b1;
        step_en = 1'b1;
        // R5: first step at edge TL+1 after release
        for (int e = 1; e <= TL; e++) @(negedge clk);
        check("R5", lamps, 8'h18);
        @(negedge clk);
        check("R5", lamps, 8'h3C);
        for (int e = 1; e <= TL; e++) @(negedge clk);
        check("R5", lamps, 8'h3C);
        @(negedge clk);
        check("R5", lamps, 8'h7E);
        drive(1'b1, 30);            // R1: wraps past 0x81
        drive(1'b0, 17);            // R3: hold, odd length shifts phase
        check("R3", lamps, exp_q.size() > 0 ? exp_q[0] : lamps);
        drive(1'b1, 23);            // R6: resume on running strobe phase
        for (int k = 0; k < 40; k++) drive(k % 3 != 0, 1);
        drive(1'b0, 2);
        drive(1'b1, 3);
        #3;
        rst_n = 1'b0;               // R4: asynchronous, off the edge
        #1;
        check("R4", lamps, 8'h18);
        @(negedge clk);
        check("R4", lamps, 8'h18);
        rst_n = 1'b1;
        for (int e = 1; e <= TL; e++) @(negedge clk);
        check("R4", lamps, 8'h18);
        @(negedge clk);
        check("R4", lamps, 8'h3C);  // counter restarted from zero
        drive(1'b1, 35);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD*20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule